// File: doc/BRIEF.md
# Variable-Length Instruction Packing Queue

This block sits between an early-decode stage and the execute stage of a processor front end. Fetched code arrives as a stream of 16-bit words, one word per accepted cycle. The first word of every instruction carries a two-bit length code. The block gathers one, two or three words into a single complete instruction and keeps an early-decode tag with it. It then hands the instruction to the consumer as one entry. The consumer therefore takes exactly one entry per instruction and never has to look at lengths or word boundaries.

Finished instructions wait in a small in-order store, four entries by default. When the store is empty and the consumer is ready, a finished instruction skips the store. It appears on the outputs in the same cycle its last word is accepted. A flush input, used when the fetch stream is redirected, drops every stored entry and any half-gathered instruction at once. The fetch side sees backpressure through a ready signal whenever the store is full.

Top module: `ipq_top`

## Requirements
- R1: The length code sits in bits [15:14] of the first word of an instruction. Code 2'b01 means one word, 2'b10 two words, 2'b11 three words, and 2'b00 is taken as one word. out_len_o gives the resolved word count (1, 2 or 3).
- R2: Words are gathered across accepted cycles, and idle cycles may fall between them. The first word is delivered on out_words_o[15:0], the second on [31:16] and the third on [47:32]. Slots beyond the length read as zero.
- R3: The tag present with the first word is delivered with the instruction. Tag values driven with later words are ignored.
- R4: With the store empty and out_ready_i high, a finished instruction is on the outputs with out_valid_o high during the cycle its last word is accepted. It is consumed without occupying the store.
- R5: Instructions leave in the order their first words arrived. Stored entries always leave before an instruction that finishes later, and a stored entry is always offered on the outputs.
- R6: The store holds 4 entries. While it is full, in_ready_o is low and an offered word is not taken.
- R7: In a cycle with flush_i high, out_valid_o is low and the word on the input is ignored. After that cycle the store is empty and any partly gathered instruction is gone.
- R8: While out_valid_o is high and out_ready_i is low, the outputs hold their values into the next cycle unless a flush intervenes.
- R9: After reset, out_valid_o is low, in_ready_o is high and no partial instruction is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Drop all stored and partly gathered instructions |
| in_valid_i | input | 1 | A fetched word is offered |
| in_word_i | input | 16 | Fetched word |
| in_tag_i | input | 4 | Early-decode tag, sampled with the first word |
| in_ready_o | output | 1 | Word can be accepted (store not full) |
| out_valid_o | output | 1 | A complete instruction is offered |
| out_ready_i | input | 1 | Consumer takes the offered instruction |
| out_words_o | output | 48 | Instruction words, first word lowest |
| out_len_o | output | 2 | Instruction length in words |
| out_tag_o | output | 4 | Tag of the offered instruction |

## Verification
The bench goes after ordering when stored entries are draining and new instructions finish at the same time. A design that lets a finished instruction bypass a non-empty store would deliver it ahead of older ones. Flush is issued while a three-word instruction is half gathered and a word is on the input. Leftover state would make the next two-word instruction come out with a wrong length or with stale words. Full-store cycles check that a one-word instruction offered then is never delivered and that the offered head holds still. Tags that change between words catch a design that samples the tag at the last word instead of the first.

// File: rtl/ipq_pkg.sv
package ipq_pkg;

   localparam int unsigned LEN_W = 2;

   typedef enum logic [LEN_W-1:0] {
      LC_DEFAULT = 2'b00,
      LC_ONE     = 2'b01,
      LC_TWO     = 2'b10,
      LC_THREE   = 2'b11
   } len_code_e;

   // Resolve a raw length code to a word count; the reserved code counts as one word.
   function automatic logic [LEN_W-1:0] resolve_len(input logic [LEN_W-1:0] code);
      return (code == LC_DEFAULT) ? LEN_W'(1) : code;
   endfunction

endpackage

// File: rtl/ipq_assembler.sv
module ipq_assembler
   import ipq_pkg::*;
#(
   parameter int unsigned WORD_W    = 16,
   parameter int unsigned MAX_WORDS = 3,
   parameter int unsigned TAG_W     = 4,
   parameter int unsigned LEN_LSB   = 14,
   localparam int unsigned SLOT_W   = WORD_W * MAX_WORDS
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_i,
   input  logic              take_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic [TAG_W-1:0]  tag_i,
   output logic              done_o,
   output logic [SLOT_W-1:0] words_o,
   output logic [LEN_W-1:0]  len_o,
   output logic [TAG_W-1:0]  tag_o
);

   logic [LEN_W-1:0]  cnt_q;
   logic [LEN_W-1:0]  len_q;
   logic [TAG_W-1:0]  tag_q;
   logic [WORD_W-1:0] held_q [MAX_WORDS];

   logic              first_w;
   logic              last_w;
   logic [LEN_W-1:0]  raw_len;
   logic [LEN_W-1:0]  cur_len;

   assign first_w = (cnt_q == '0);
   assign raw_len = resolve_len(word_i[LEN_LSB +: LEN_W]);
   assign cur_len = first_w ? ((raw_len > LEN_W'(MAX_WORDS)) ? LEN_W'(MAX_WORDS) : raw_len)
                            : len_q;
   assign last_w  = ((cnt_q + LEN_W'(1)) == cur_len);

   assign done_o  = take_i & last_w;
   assign len_o   = cur_len;
   assign tag_o   = first_w ? tag_i : tag_q;

   for (genvar k = 0; k < MAX_WORDS; k++) begin : g_slot
      assign words_o[k*WORD_W +: WORD_W] =
         (LEN_W'(k) < cnt_q)                ? held_q[k] :
         ((LEN_W'(k) == cnt_q) && take_i)   ? word_i    : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         len_q <= '0;
         tag_q <= '0;
      end else if (flush_i) begin
         cnt_q <= '0;
      end else if (take_i) begin
         if (last_w) begin
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + LEN_W'(1);
            if (first_w) begin
               len_q <= cur_len;
               tag_q <= tag_i;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      for (int k = 0; k < MAX_WORDS; k++) begin
         if (take_i && !last_w && (cnt_q == LEN_W'(k))) begin
            held_q[k] <= word_i;
         end
      end
   end

endmodule

// File: rtl/ipq_store.sv
module ipq_store #(
   parameter int unsigned ENT_W  = 54,
   parameter int unsigned DEPTH  = 4,
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1),
   localparam bit          POW2  = ((DEPTH & (DEPTH - 1)) == 0)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush_i,
   input  logic             push_i,
   input  logic             pop_i,
   input  logic [ENT_W-1:0] ent_i,
   output logic [ENT_W-1:0] head_o,
   output logic             empty_o,
   output logic             full_o
);

   logic [ENT_W-1:0] mem_q [DEPTH];
   logic [PTR_W-1:0] wptr_q, rptr_q;
   logic [PTR_W-1:0] wptr_nx, rptr_nx;
   logic [CNT_W-1:0] fill_q;

   if (POW2) begin : g_wrap_free
      assign wptr_nx = wptr_q + PTR_W'(1);
      assign rptr_nx = rptr_q + PTR_W'(1);
   end else begin : g_wrap_cmp
      assign wptr_nx = (wptr_q == PTR_W'(DEPTH - 1)) ? '0 : wptr_q + PTR_W'(1);
      assign rptr_nx = (rptr_q == PTR_W'(DEPTH - 1)) ? '0 : rptr_q + PTR_W'(1);
   end

   assign head_o  = mem_q[rptr_q];
   assign empty_o = (fill_q == '0);
   assign full_o  = (fill_q == CNT_W'(DEPTH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q <= '0;
         rptr_q <= '0;
         fill_q <= '0;
      end else if (flush_i) begin
         wptr_q <= '0;
         rptr_q <= '0;
         fill_q <= '0;
      end else begin
         if (push_i) wptr_q <= wptr_nx;
         if (pop_i)  rptr_q <= rptr_nx;
         case ({push_i, pop_i})
            2'b10:   fill_q <= fill_q + CNT_W'(1);
            2'b01:   fill_q <= fill_q - CNT_W'(1);
            default: fill_q <= fill_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push_i && !flush_i) begin
         mem_q[wptr_q] <= ent_i;
      end
   end

endmodule

// File: rtl/ipq_out_sel.sv
module ipq_out_sel #(
   parameter int unsigned ENT_W = 54
)(
   input  logic             flush_i,
   input  logic             asm_done_i,
   input  logic [ENT_W-1:0] asm_ent_i,
   input  logic [ENT_W-1:0] head_i,
   input  logic             empty_i,
   input  logic             out_ready_i,
   output logic             out_valid_o,
   output logic [ENT_W-1:0] out_ent_o,
   output logic             push_o,
   output logic             pop_o
);

   logic bypass;

   // Skipping the store is only allowed when nothing older waits in it.
   assign bypass      = asm_done_i & empty_i & out_ready_i;
   assign push_o      = asm_done_i & ~bypass;
   assign pop_o       = ~flush_i & ~empty_i & out_ready_i;
   assign out_valid_o = ~flush_i & (~empty_i | asm_done_i);
   assign out_ent_o   = empty_i ? asm_ent_i : head_i;

endmodule

// File: rtl/ipq_top.sv
module ipq_top
   import ipq_pkg::*;
#(
   parameter int unsigned WORD_W    = 16,
   parameter int unsigned MAX_WORDS = 3,
   parameter int unsigned TAG_W     = 4,
   parameter int unsigned DEPTH     = 4,
   parameter int unsigned LEN_LSB   = 14
)(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        flush_i,
   input  logic                        in_valid_i,
   input  logic [WORD_W-1:0]           in_word_i,
   input  logic [TAG_W-1:0]            in_tag_i,
   output logic                        in_ready_o,
   output logic                        out_valid_o,
   input  logic                        out_ready_i,
   output logic [WORD_W*MAX_WORDS-1:0] out_words_o,
   output logic [LEN_W-1:0]            out_len_o,
   output logic [TAG_W-1:0]            out_tag_o
);

   localparam int unsigned SLOT_W = WORD_W * MAX_WORDS;
   localparam int unsigned ENT_W  = TAG_W + LEN_W + SLOT_W;

   if (MAX_WORDS < 1 || MAX_WORDS > 3) begin : g_bad_words
      $error("ipq_top: MAX_WORDS must be 1..3");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("ipq_top: DEPTH must be at least 2");
   end
   if (LEN_LSB + LEN_W > WORD_W) begin : g_bad_field
      $error("ipq_top: length field lies outside the word");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("ipq_top: TAG_W must be at least 1");
   end

   logic              take;
   logic              asm_done;
   logic [SLOT_W-1:0] asm_words;
   logic [LEN_W-1:0]  asm_len;
   logic [TAG_W-1:0]  asm_tag;
   logic [ENT_W-1:0]  asm_ent;
   logic [ENT_W-1:0]  head_ent;
   logic [ENT_W-1:0]  out_ent;
   logic              store_empty;
   logic              store_full;
   logic              push;
   logic              pop;

   assign in_ready_o = ~store_full;
   assign take       = in_valid_i & ~store_full & ~flush_i;
   assign asm_ent    = {asm_tag, asm_len, asm_words};

   ipq_assembler #(
      .WORD_W    (WORD_W),
      .MAX_WORDS (MAX_WORDS),
      .TAG_W     (TAG_W),
      .LEN_LSB   (LEN_LSB)
   ) u_asm (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush_i (flush_i),
      .take_i  (take),
      .word_i  (in_word_i),
      .tag_i   (in_tag_i),
      .done_o  (asm_done),
      .words_o (asm_words),
      .len_o   (asm_len),
      .tag_o   (asm_tag)
   );

   ipq_store #(
      .ENT_W (ENT_W),
      .DEPTH (DEPTH)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush_i (flush_i),
      .push_i  (push),
      .pop_i   (pop),
      .ent_i   (asm_ent),
      .head_o  (head_ent),
      .empty_o (store_empty),
      .full_o  (store_full)
   );

   ipq_out_sel #(
      .ENT_W (ENT_W)
   ) u_sel (
      .flush_i     (flush_i),
      .asm_done_i  (asm_done),
      .asm_ent_i   (asm_ent),
      .head_i      (head_ent),
      .empty_i     (store_empty),
      .out_ready_i (out_ready_i),
      .out_valid_o (out_valid_o),
      .out_ent_o   (out_ent),
      .push_o      (push),
      .pop_o       (pop)
   );

   assign out_tag_o   = out_ent[ENT_W-1 -: TAG_W];
   assign out_len_o   = out_ent[SLOT_W +: LEN_W];
   assign out_words_o = out_ent[SLOT_W-1:0];

endmodule

// File: rtl/ipq_checker.sv
module ipq_checker #(
   parameter int unsigned WORD_W    = 16,
   parameter int unsigned MAX_WORDS = 3,
   parameter int unsigned TAG_W     = 4,
   parameter int unsigned LEN_W     = 2
)(
   input logic                        clk,
   input logic                        rst_n,
   input logic                        flush_i,
   input logic                        out_valid_o,
   input logic                        out_ready_i,
   input logic [WORD_W*MAX_WORDS-1:0] out_words_o,
   input logic [LEN_W-1:0]            out_len_o,
   input logic [TAG_W-1:0]            out_tag_o,
   input logic                        store_empty,
   input logic                        store_full,
   input logic                        push
);

   AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_o |-> (out_len_o != '0) && (out_len_o <= LEN_W'(MAX_WORDS))); // R1

   AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_o |-> ((out_words_o >> (WORD_W * out_len_o)) == '0)); // R2

   AST_STORED_OFFERED: assert property (@(posedge clk) disable iff (!rst_n)
      (!store_empty && !flush_i) |-> out_valid_o); // R5

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      store_full |-> !push); // R6

   AST_FLUSH_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |-> !out_valid_o); // R7

   AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> store_empty); // R7

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && !out_ready_i && !flush_i) |=>
         (flush_i || (out_valid_o && $stable(out_words_o) &&
                      $stable(out_len_o) && $stable(out_tag_o)))); // R8

endmodule

bind ipq_top ipq_checker #(
   .WORD_W    (WORD_W),
   .MAX_WORDS (MAX_WORDS),
   .TAG_W     (TAG_W),
   .LEN_W     (ipq_pkg::LEN_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .flush_i     (flush_i),
   .out_valid_o (out_valid_o),
   .out_ready_i (out_ready_i),
   .out_words_o (out_words_o),
   .out_len_o   (out_len_o),
   .out_tag_o   (out_tag_o),
   .store_empty (store_empty),
   .store_full  (store_full),
   .push        (push)
);

// File: tb/ipq_top_tb_top.sv
module ipq_top_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush_i = 1'b0;
   logic        in_valid_i = 1'b0;
   logic [15:0] in_word_i = '0;
   logic [3:0]  in_tag_i = '0;
   logic        in_ready_o;
   logic        out_valid_o;
   logic        out_ready_i = 1'b0;
   logic [47:0] out_words_o;
   logic [1:0]  out_len_o;
   logic [3:0]  out_tag_o;

   int n_checks = 0;
   int n_errs   = 0;
   bit finished = 1'b0;
   logic [53:0] expq[$];
   logic [53:0] mon_e;

   always #10 clk = ~clk;

   ipq_top dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .flush_i     (flush_i),
      .in_valid_i  (in_valid_i),
      .in_word_i   (in_word_i),
      .in_tag_i    (in_tag_i),
      .in_ready_o  (in_ready_o),
      .out_valid_o (out_valid_o),
      .out_ready_i (out_ready_i),
      .out_words_o (out_words_o),
      .out_len_o   (out_len_o),
      .out_tag_o   (out_tag_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_errs++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   function automatic logic [53:0] cur_out();
      return {out_tag_o, out_len_o, out_words_o};
   endfunction

   // Scoreboard: every handshake must match the oldest expected instruction (R5).
   initial begin
      forever begin
         @(posedge clk);
         #16;
         if (rst_n && out_valid_o && out_ready_i) begin
            if (expq.size() == 0) begin
               chk(1'b0, "R5", "unexpected instruction", 64'(cur_out()), 64'd0);
            end else begin
               mon_e = expq.pop_front();
               chk(cur_out() == mon_e, "R5", "delivered entry", 64'(cur_out()), 64'(mon_e));
            end
         end
      end
   end

   function automatic logic [47:0] build_words(input int n, input logic [1:0] code,
                                               input logic [15:0] base);
      logic [47:0] w = '0;
      w[15:0] = {code, base[13:0]};
      for (int i = 1; i < n; i++) w[i*16 +: 16] = base + 16'(i * 3);
      return w;
   endfunction

   task automatic send_word(input logic [15:0] wd, input logic [3:0] tg);
      bit took = 1'b0;
      in_valid_i = 1'b1;
      in_word_i  = wd;
      in_tag_i   = tg;
      while (!took) begin
         #14;
         took = in_ready_o;
         step();
      end
      in_valid_i = 1'b0;
   endtask

   // Later words carry an inverted tag, which must be ignored (R3).
   task automatic send_instr(input int n, input logic [1:0] code, input logic [3:0] tag,
                             input logic [15:0] base, input int gap);
      logic [47:0] w = build_words(n, code, base);
      expq.push_back({tag, 2'(n), w});
      for (int i = 0; i < n; i++) begin
         send_word(w[i*16 +: 16], (i == 0) ? tag : ~tag);
         repeat (gap) step();
      end
   endtask

   task automatic drain(input string req);
      for (int i = 0; i < 60 && expq.size() > 0; i++) step();
      chk(expq.size() == 0, req, "instructions still pending", 64'(expq.size()), 64'd0);
   endtask

   task automatic t_reset();
      repeat (3) @(posedge clk);
      #2;
      chk(out_valid_o == 1'b0, "R9", "out_valid in reset", 64'(out_valid_o), 64'd0);
      chk(in_ready_o == 1'b1, "R9", "in_ready in reset", 64'(in_ready_o), 64'd1);
      rst_n = 1'b1;
      step();
      #14;
      chk(out_valid_o == 1'b0, "R9", "out_valid after reset", 64'(out_valid_o), 64'd0);
      step();
   endtask

   task automatic t_bypass();
      logic [47:0] w;
      out_ready_i = 1'b1;
      // one-word instruction straight through in its own cycle
      w = build_words(1, 2'b01, 16'h0123);
      expq.push_back({4'h5, 2'd1, w});
      in_valid_i = 1'b1; in_word_i = w[15:0]; in_tag_i = 4'h5;
      #14;
      chk(out_valid_o == 1'b1, "R4", "bypass valid same cycle", 64'(out_valid_o), 64'd1);
      chk(out_words_o == w, "R4", "bypass words", 64'(out_words_o), 64'(w));
      step();
      in_valid_i = 1'b0;
      #14;
      chk(out_valid_o == 1'b0, "R4", "bypassed entry not stored", 64'(out_valid_o), 64'd0);
      step();
      // three-word instruction: valid appears only at the last word
      w = build_words(3, 2'b11, 16'h0a00);
      expq.push_back({4'h9, 2'd3, w});
      for (int i = 0; i < 3; i++) begin
         in_valid_i = 1'b1; in_word_i = w[i*16 +: 16]; in_tag_i = (i == 0) ? 4'h9 : 4'h2;
         #14;
         chk(out_valid_o == (i == 2), "R4", "valid only on last word", 64'(out_valid_o), 64'(i == 2));
         step();
      end
      in_valid_i = 1'b0;
      drain("R4");
   endtask

   task automatic t_lengths();
      out_ready_i = 1'b1;
      send_instr(1, 2'b01, 4'h1, 16'h1000, 0);
      send_instr(2, 2'b10, 4'h2, 16'h2000, 1);
      send_instr(3, 2'b11, 4'h3, 16'h3000, 2);
      send_instr(1, 2'b00, 4'h4, 16'h0444, 0);   // R1: code 00 resolves to one word
      send_instr(3, 2'b11, 4'h6, 16'h3abc, 0);   // R2: back-to-back mix
      send_instr(2, 2'b10, 4'h7, 16'h2def, 0);
      send_instr(1, 2'b01, 4'h8, 16'h1fff, 0);
      drain("R2");
      chk(n_errs == 0, "R3", "tag and length checks so far", 64'(n_errs), 64'd0);
   endtask

   task automatic t_full();
      logic [53:0] snap;
      out_ready_i = 1'b0;
      send_instr(1, 2'b01, 4'ha, 16'h1111, 0);
      send_instr(3, 2'b11, 4'hb, 16'h2222, 0);
      send_instr(2, 2'b10, 4'hc, 16'h3333, 0);
      send_instr(1, 2'b00, 4'hd, 16'h0044, 0);
      #14;
      chk(in_ready_o == 1'b0, "R6", "in_ready when full", 64'(in_ready_o), 64'd0);
      snap = cur_out();
      chk(snap == expq[0], "R8", "head offered", 64'(snap), 64'(expq[0]));
      step();
      in_valid_i = 1'b1; in_word_i = 16'h4555; in_tag_i = 4'he;   // one-word instruction
      for (int i = 0; i < 3; i++) begin
         #14;
         chk(in_ready_o == 1'b0, "R6", "still full", 64'(in_ready_o), 64'd0);
         chk(out_valid_o == 1'b1 && cur_out() == snap, "R8", "held output",
             64'(cur_out()), 64'(snap));
         step();
      end
      in_valid_i = 1'b0;
      out_ready_i = 1'b1;
      drain("R6");
      repeat (3) step();
      #14;
      chk(out_valid_o == 1'b0, "R6", "word offered while full not taken", 64'(out_valid_o), 64'd0);
      step();
   endtask

   task automatic t_order();
      out_ready_i = 1'b0;
      send_instr(2, 2'b10, 4'h1, 16'h2a00, 0);
      send_instr(3, 2'b11, 4'h2, 16'h3b00, 0);
      out_ready_i = 1'b1;
      send_instr(1, 2'b01, 4'h3, 16'h1c00, 0);
      send_instr(1, 2'b01, 4'h4, 16'h1d00, 0);
      send_instr(2, 2'b10, 4'h5, 16'h2e00, 0);
      drain("R5");
      // alternate readiness while new instructions keep arriving
      fork
         begin
            send_instr(3, 2'b11, 4'h6, 16'h3f00, 0);
            send_instr(1, 2'b01, 4'h7, 16'h1e10, 0);
            send_instr(2, 2'b10, 4'h8, 16'h2e20, 0);
            send_instr(1, 2'b00, 4'h9, 16'h0e30, 0);
         end
         begin
            for (int i = 0; i < 10; i++) begin
               out_ready_i = i[0];
               step();
            end
            out_ready_i = 1'b1;
         end
      join
      drain("R5");
   endtask

   task automatic t_flush();
      out_ready_i = 1'b0;
      send_instr(1, 2'b01, 4'h1, 16'h1700, 0);
      send_instr(2, 2'b10, 4'h2, 16'h2700, 0);
      send_word({2'b11, 14'h0777}, 4'h3);   // first word of a three-word instruction
      flush_i = 1'b1;
      in_valid_i = 1'b1; in_word_i = {2'b01, 14'h0999}; in_tag_i = 4'h4;
      #14;
      chk(out_valid_o == 1'b0, "R7", "valid low during flush", 64'(out_valid_o), 64'd0);
      step();
      flush_i = 1'b0;
      in_valid_i = 1'b0;
      expq.delete();
      #14;
      chk(out_valid_o == 1'b0, "R7", "store empty after flush", 64'(out_valid_o), 64'd0);
      chk(in_ready_o == 1'b1, "R7", "ready after flush", 64'(in_ready_o), 64'd1);
      step();
      out_ready_i = 1'b1;
      send_instr(2, 2'b10, 4'h6, 16'h2800, 0);   // wrong length if the partial survived
      drain("R7");
   endtask

   initial begin
      t_reset();
      t_bypass();
      t_lengths();
      t_full();
      t_order();
      t_flush();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         chk(1'b0, "R5", "watchdog expired", 64'd0, 64'd1);
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
         $finish;
      end
   end

endmodule